// File: doc/BRIEF.md
# Validated Master Priority Register Arbiter

This block holds the arbitration priorities that five bus masters have on one slave port, and uses them to grant that port. A single 32-bit configuration word carries a 3-bit level for each master. Software reads and writes the word through a simple strobe interface. Every access must be made in supervisor mode.

A write is committed only when all five levels in the new word differ from each other. A write is refused when it would create a duplicate level, when the lock input is high, or when the access is not supervisor. A refused write raises a bus error in the same cycle as the strobe and leaves the word unchanged.

On the request side, each cycle the block picks, from the masters that are requesting, the one whose level code is smallest. It presents that choice as a registered one-hot grant on the next cycle. Grant selection always uses the committed word, never a write that is still in flight.

Top module: `prio_cfg_arbiter`

## Requirements
- R1: After reset the word reads 0x4302_0010. Masters 0,1,2,3,4 then hold level codes 0,1,2,3,4, and no grant is asserted.
- R2: Each master's 3-bit code sits at a fixed position: master 0 at bits [2:0], master 1 at [6:4], master 2 at [18:16], master 3 at [26:24] and master 4 at [30:28]. All other bits (mask 0x88F8_FF88) always read as zero. Write data in those bits is discarded and plays no part in the duplicate check.
- R3: A supervisor read (rd_en=1, supervisor=1) shows the committed word on rdata in the same cycle, without bus_err. Otherwise rdata is zero.
- R4: Any access with supervisor=0 raises bus_err in that cycle and leaves the word unchanged.
- R5: While lock=1, reads still work, but a write raises bus_err in that cycle and leaves the word unchanged.
- R6: A supervisor write whose five codes are not pairwise distinct raises bus_err in that cycle and leaves the word unchanged.
- R7: A supervisor write with lock=0 and five distinct codes raises no bus_err. It is visible on the following cycle as the write data with the bits of the R2 mask cleared.
- R8: One cycle after a request pattern is presented, gnt is one-hot and names the requesting master with the smallest code (code 000 is the highest priority).
- R9: When no master requests, gnt is all zero on the following cycle.
- R10: A grant is chosen with the word committed at the edge where it is sampled. A write in the same cycle as the request does not affect that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| supervisor | input | 1 | Access is in supervisor mode |
| lock | input | 1 | Makes the word read-only |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not read |
| bus_err | output | 1 | Error response for the current access |
| req | input | 5 | Per-master request |
| gnt | output | 5 | Registered one-hot grant |

## Verification
bus_err and rdata are combinational, so the bench checks them after it drives the strobe and before the next rising edge. A committed write and a grant each appear one edge later, so the bench checks them just after that edge. The bench applies every one of the 32768 code combinations as a write. For each one it predicts from arithmetic whether the write is refused, and checks the previous word on rdata. All 32 request patterns are swept under several committed orderings. One test writes and requests in the same cycle, to confirm that the grant follows the old word.

// File: rtl/prio_cfg_arbiter.sv
module prio_cfg_arbiter #(
  parameter int NM = 5,
  parameter int FW = 3,
  parameter int DW = 32,
  parameter int FOFS [NM] = '{0, 4, 16, 24, 28},
  parameter logic [DW-1:0] RST_VAL = 32'h4302_0010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          supervisor,
  input  logic          lock,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bus_err,
  input  logic [NM-1:0] req,
  output logic [NM-1:0] gnt
);

  function automatic logic [DW-1:0] field_mask();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NM; i++) m[FOFS[i] +: FW] = '1;
    return m;
  endfunction

  localparam logic [DW-1:0] FMASK = field_mask();

  logic [DW-1:0] cfg;
  logic [FW-1:0] fld_w [NM];
  logic [FW-1:0] fld_c [NM];
  logic          dup, wr_ok;
  logic [NM-1:0] gnt_n;

  always_comb
    for (int i = 0; i < NM; i++) begin
      fld_w[i] = wdata[FOFS[i] +: FW];
      fld_c[i] = cfg[FOFS[i] +: FW];
    end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NM; i++)
      for (int j = i + 1; j < NM; j++)
        if (fld_w[i] == fld_w[j]) dup = 1'b1;
  end

  assign wr_ok   = wr_en & supervisor & ~lock & ~dup;
  assign bus_err = ((wr_en | rd_en) & ~supervisor) | (wr_en & supervisor & (lock | dup));
  assign rdata   = (rd_en & supervisor) ? cfg : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cfg <= RST_VAL & FMASK;
    else if (wr_ok) cfg <= wdata & FMASK;

  always_comb begin
    logic [FW-1:0] best;
    logic          found;
    best  = '1;
    found = 1'b0;
    gnt_n = '0;
    for (int i = 0; i < NM; i++)
      if (req[i] && (!found || fld_c[i] < best)) begin
        best  = fld_c[i];
        found = 1'b1;
        gnt_n = '0;
        gnt_n[i] = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gnt <= '0;
    else        gnt <= gnt_n;

  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_from_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((gnt & $past(req)) != '0));

  assert_idle_no_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt == '0));

  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_err) |=> $stable(cfg));

  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(cfg));

  assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_err) |=> (cfg == ($past(wdata) & FMASK)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~FMASK) == '0));

endmodule

// File: tb/tb_prio_cfg_arbiter.sv
module tb_prio_cfg_arbiter;
  localparam logic [31:0] RES = 32'h88F8_FF88;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0, supervisor = 0, lock = 0;
  logic [31:0] wdata = 0, rdata;
  logic        bus_err;
  logic [4:0]  req = 0, gnt;

  int checks = 0, fails = 0;
  logic [31:0] model;
  bit done = 0;

  prio_cfg_arbiter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .supervisor(supervisor), .lock(lock), .wdata(wdata), .rdata(rdata),
    .bus_err(bus_err), .req(req), .gnt(gnt));

  always #2 clk = ~clk;

  function automatic int ofs(int i);
    case (i) 0: return 0; 1: return 4; 2: return 16; 3: return 24; default: return 28; endcase
  endfunction

  function automatic logic [31:0] pack(int f0, int f1, int f2, int f3, int f4);
    logic [31:0] v = '0;
    v[2:0] = 3'(f0); v[6:4] = 3'(f1); v[18:16] = 3'(f2); v[26:24] = 3'(f3); v[30:28] = 3'(f4);
    return v;
  endfunction

  function automatic bit has_dup(logic [31:0] w);
    for (int i = 0; i < 5; i++)
      for (int j = i + 1; j < 5; j++)
        if (w[ofs(i) +: 3] == w[ofs(j) +: 3]) return 1;
    return 0;
  endfunction

  function automatic logic [4:0] exp_gnt(logic [31:0] w, logic [4:0] r);
    int best = 99; logic [4:0] g = '0;
    for (int i = 0; i < 5; i++)
      if (r[i] && int'(w[ofs(i) +: 3]) < best) begin best = int'(w[ofs(i) +: 3]); g = 5'(1) << i; end
    return g;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic grant_sweep(string rq);
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); req = 5'(p);
      @(posedge clk); #1;
      chk(p == 0 ? "R9" : rq, 32'(gnt), 32'(exp_gnt(model, 5'(p))));
    end
    @(negedge clk); req = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = 32'h4302_0010;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    supervisor = 1; rd_en = 1; #1;
    chk("R1", rdata, 32'h4302_0010);
    chk("R1", 32'(gnt), 0);
    chk("R3", 32'(bus_err), 0);
    rd_en = 0; #1;
    chk("R3", rdata, 0);

    // user-mode read and write
    @(negedge clk); supervisor = 0; rd_en = 1; #1;
    chk("R4", 32'(bus_err), 1);
    chk("R4", rdata, 0);
    rd_en = 0; wr_en = 1; wdata = pack(4, 3, 2, 1, 0); #1;
    chk("R4", 32'(bus_err), 1);
    @(negedge clk); wr_en = 0; supervisor = 1; rd_en = 1; #1;
    chk("R4", rdata, model);

    // locked write
    lock = 1; wr_en = 1; wdata = pack(4, 3, 2, 1, 0); #1;
    chk("R5", 32'(bus_err), 1);
    chk("R5", rdata, model);
    @(negedge clk); wr_en = 0; #1;
    chk("R5", rdata, model);
    chk("R5", 32'(bus_err), 0);
    lock = 0;

    // reserved bits discarded, not used in duplicate check
    @(negedge clk); wr_en = 1; wdata = pack(1, 0, 3, 2, 4) | RES; #1;
    chk("R2", 32'(bus_err), 0);
    @(negedge clk); wr_en = 0; #1;
    model = pack(1, 0, 3, 2, 4);
    chk("R2", rdata, model);
    grant_sweep("R8");

    // exhaustive write sweep
    for (int c = 0; c < 32768; c++) begin
      logic [31:0] w;
      @(negedge clk);
      w = pack(c & 7, (c >> 3) & 7, (c >> 6) & 7, (c >> 9) & 7, (c >> 12) & 7);
      wr_en = 1; rd_en = 1;
      wdata = w | (RES & {c[7:0], c[15:8], c[7:0], c[15:8]}); #1;
      chk(has_dup(w) ? "R6" : "R7", 32'(bus_err), 32'(has_dup(w)));
      chk("R3", rdata, model);
      if (!has_dup(w)) model = w;
    end
    @(negedge clk); wr_en = 0; #1;
    chk("R7", rdata, model);

    // reverse order, then grant sweep
    wr_en = 1; wdata = pack(4, 3, 2, 1, 0); #1;
    chk("R7", 32'(bus_err), 0);
    @(negedge clk); wr_en = 0; #1;
    model = pack(4, 3, 2, 1, 0);
    chk("R7", rdata, model);
    grant_sweep("R8");

    // write and request in the same cycle: grant uses old word
    @(negedge clk); wr_en = 1; wdata = pack(0, 1, 2, 3, 4); req = 5'b10001;
    @(posedge clk); #1;
    chk("R10", 32'(gnt), 32'(5'b10000));
    @(negedge clk); wr_en = 0; req = 5'b10001;
    model = pack(0, 1, 2, 3, 4);
    @(posedge clk); #1;
    chk("R10", 32'(gnt), 32'(5'b00001));
    grant_sweep("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule